// File: doc/BRIEF.md
# Key-Gated Locked ALU Slice

This block computes a small registered arithmetic and logic function over two operands. Selected internal nets carry key gates. A key gate is a two-input XOR or XNOR. One input is the net and the other is one bit of an on-chip key register. The gate output takes over the net's loads. A key bit that matches its secret value lets the net through unchanged. A key bit that does not match flips the net. The function then keeps running but gives wrong answers, and each wrong bit damages only its own net.

The key register clears to zero on reset, and the secret key is not zero, so a fresh device computes wrong results. An activation port writes the key in parallel or shifts it in one bit at a time. A lock command then freezes the key until the next reset. A match flag reports whether the stored key equals the secret. It serves verification only and can be dropped from a production netlist. The gate type and an inversion folded into the driving logic are set per bit, so the secret value of a bit cannot be read from which kind of gate sits on the net.

Top module: `keylock_alu`

## Requirements
- R1: After reset the key register is all zeros, the lock flag is clear, `y` is 0, `out_vld` is 0 and `key_ok` is 0.
- R2: With the correct key loaded, when `in_vld` is high the next clock edge sets `y` to `op_a + op_b` for `op_sel`=0, `op_a - op_b` for 1, `op_a & op_b` for 2 and `op_a ^ op_b` for 3, all modulo 2^DATA_W.
- R3: Let HALF be KEY_W/2. For i below HALF, a key bit i that differs from the secret inverts operand A bit i before the function. For i at or above HALF, it inverts operand B bit i-HALF. Each bit acts on its own net only.
- R4: While the lock flag is clear, `key_wr` loads `key_wdata` into the key register at the clock edge.
- R5: While the lock flag is clear and `key_wr` is low, `key_sh` shifts the key register one place toward its MSB and puts `key_sin` in bit 0. If `key_wr` and `key_sh` are both high, the parallel write wins.
- R6: `lock_set` sets the lock flag at the clock edge, and the flag stays set until reset. While it is set, writes and shifts leave the key unchanged. A write in the same cycle as `lock_set` is still accepted.
- R7: `key_ok` is high exactly when every key bit equals its secret value.
- R8: `out_vld` follows `in_vld` one clock later. When `in_vld` is low, `y` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Operands valid this cycle |
| op_a | input | DATA_W | Operand A |
| op_b | input | DATA_W | Operand B |
| op_sel | input | 2 | Function select: 0 add, 1 subtract, 2 and, 3 xor |
| key_wr | input | 1 | Parallel key write strobe |
| key_wdata | input | KEY_W | Parallel key value |
| key_sh | input | 1 | Serial key shift strobe |
| key_sin | input | 1 | Serial key bit shifted into bit 0 |
| lock_set | input | 1 | Lock command; freezes the key until reset |
| y | output | DATA_W | Registered function result |
| out_vld | output | 1 | `y` updated from valid operands |
| key_ok | output | 1 | Stored key equals the secret (verification aid) |
| locked | output | 1 | Lock flag |

## Verification
The bench uses DATA_W=8, KEY_W=8, secret key 8'hA5 and pushed-inversion mask 8'h3C. In the low nibble these values give all four pairings of gate type and folded inversion, so every gate form is tested with the right and the wrong key value. Walking a single wrong bit across all eight positions shows that each bit corrupts only its own operand bit, on operand A and on operand B. The 8-bit width keeps the add carry-out and the subtract borrow wrap easy to reach.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  // One cycle's worth of activation-port requests.
  typedef struct packed {
    logic wr;
    logic sh;
    logic sin;
    logic lock;
  } key_cmd_t;

endpackage

// File: rtl/keylock_keyreg.sv
module keylock_keyreg
  import keylock_pkg::*;
#(
  parameter int                KEY_W       = 8,
  parameter logic [KEY_W-1:0]  CORRECT_KEY = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  key_cmd_t         cmd,
  input  logic [KEY_W-1:0] wdata,
  output logic [KEY_W-1:0] key_q,
  output logic             locked_q,
  output logic             match
);

  logic [KEY_W-1:0] key_d;
  logic             key_en;
  logic             lock_d;

  // Next-state: parallel write has priority over shift; the lock flag
  // that gates the update is the registered one, so a write issued in
  // the lock cycle still lands.
  always_comb begin
    key_en = ~locked_q & (cmd.wr | cmd.sh);
    if (cmd.wr) begin
      key_d = wdata;
    end else begin
      key_d = {key_q[KEY_W-2:0], cmd.sin};
    end
    lock_d = locked_q | cmd.lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (key_en) begin
        key_q <= key_d;
      end
      locked_q <= lock_d;
    end
  end

  assign match = (key_q == CORRECT_KEY);

endmodule

// File: rtl/keylock_gate.sv
module keylock_gate #(
  parameter bit FOLD_INV = 1'b0,
  parameter bit USE_XNOR = 1'b0
) (
  input  logic net_in,
  input  logic key_bit,
  output logic net_out
);

  logic pre;

  // FOLD_INV stands for an inversion absorbed into the driving logic.
  assign pre = net_in ^ FOLD_INV;

  generate
    if (USE_XNOR) begin : g_xnor
      assign net_out = ~(pre ^ key_bit);
    end else begin : g_xor
      assign net_out = pre ^ key_bit;
    end
  endgenerate

endmodule

// File: rtl/keylock_gate_bank.sv
module keylock_gate_bank #(
  parameter int               N         = 8,
  parameter logic [N-1:0]     SECRET    = 8'hA5,
  parameter logic [N-1:0]     FOLD_MASK = 8'h3C
) (
  input  logic [N-1:0] nets,
  input  logic [N-1:0] key,
  output logic [N-1:0] gated
);

  // Gate type is chosen so that the secret bit cancels both the folded
  // inversion and the gate's own polarity: out = net ^ (key ^ secret).
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      keylock_gate #(
        .FOLD_INV (FOLD_MASK[i]),
        .USE_XNOR (SECRET[i] ^ FOLD_MASK[i])
      ) u_gate (
        .net_in  (nets[i]),
        .key_bit (key[i]),
        .net_out (gated[i])
      );
    end
  endgenerate

endmodule

// File: rtl/keylock_func.sv
module keylock_func
  import keylock_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] r
);

  always_comb begin
    unique case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_AND:  r = a & b;
      OP_XOR:  r = a ^ b;
      default: r = '0;
    endcase
  end

endmodule

// File: rtl/keylock_alu.sv
module keylock_alu
  import keylock_pkg::*;
#(
  parameter int               DATA_W      = 8,
  parameter int               KEY_W       = 8,
  parameter logic [KEY_W-1:0] CORRECT_KEY = 8'hA5,
  parameter logic [KEY_W-1:0] FOLD_MASK   = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        op_sel,
  input  logic              key_wr,
  input  logic [KEY_W-1:0]  key_wdata,
  input  logic              key_sh,
  input  logic              key_sin,
  input  logic              lock_set,
  output logic [DATA_W-1:0] y,
  output logic              out_vld,
  output logic              key_ok,
  output logic              locked
);

  localparam int HALF = KEY_W / 2;

  // Reset: asserted asynchronously, released after two clean edges.
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_q_n = rst_sync[1];

  // Activation register.
  key_cmd_t         cmd;
  logic [KEY_W-1:0] key_q;

  assign cmd = '{wr: key_wr, sh: key_sh, sin: key_sin, lock: lock_set};

  keylock_keyreg #(
    .KEY_W       (KEY_W),
    .CORRECT_KEY (CORRECT_KEY)
  ) u_keyreg (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .cmd      (cmd),
    .wdata    (key_wdata),
    .key_q    (key_q),
    .locked_q (locked),
    .match    (key_ok)
  );

  // Key gates on the low HALF bits of each operand.
  logic [KEY_W-1:0] nets;
  logic [KEY_W-1:0] gated;

  assign nets = {op_b[HALF-1:0], op_a[HALF-1:0]};

  keylock_gate_bank #(
    .N         (KEY_W),
    .SECRET    (CORRECT_KEY),
    .FOLD_MASK (FOLD_MASK)
  ) u_gates (
    .nets  (nets),
    .key   (key_q),
    .gated (gated)
  );

  logic [DATA_W-1:0] a_g;
  logic [DATA_W-1:0] b_g;

  always_comb begin
    a_g = op_a;
    b_g = op_b;
    a_g[HALF-1:0] = gated[HALF-1:0];
    b_g[HALF-1:0] = gated[KEY_W-1:HALF];
  end

  logic [DATA_W-1:0] res;

  keylock_func #(
    .DATA_W (DATA_W)
  ) u_func (
    .a  (a_g),
    .b  (b_g),
    .op (alu_op_e'(op_sel)),
    .r  (res)
  );

  // Output register with explicit enable.
  logic [DATA_W-1:0] y_d;
  logic              y_en;

  always_comb begin
    y_en = in_vld;
    y_d  = res;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      y       <= '0;
      out_vld <= 1'b0;
    end else begin
      if (y_en) begin
        y <= y_d;
      end
      out_vld <= in_vld;
    end
  end

endmodule

// File: rtl/keylock_alu_chk.sv
module keylock_alu_chk #(
  parameter int               DATA_W      = 8,
  parameter int               KEY_W       = 8,
  parameter logic [KEY_W-1:0] CORRECT_KEY = 8'hA5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [1:0]        op_sel,
  input logic              key_wr,
  input logic [KEY_W-1:0]  key_wdata,
  input logic              key_sh,
  input logic              key_sin,
  input logic              lock_set,
  input logic [KEY_W-1:0]  key_q,
  input logic [DATA_W-1:0] y,
  input logic              out_vld,
  input logic              key_ok,
  input logic              locked
);

  function automatic logic [DATA_W-1:0] plain(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b,
                                              input logic [1:0] s);
    case (s)
      2'd0:    plain = a + b;
      2'd1:    plain = a - b;
      2'd2:    plain = a & b;
      default: plain = a ^ b;
    endcase
  endfunction

  // R2: correct key gives the unlocked function.
  a_r2_correct_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && key_ok) |=> (y == plain($past(op_a), $past(op_b), $past(op_sel))));

  // R4: parallel load while unlocked.
  a_r4_par_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && key_wr) |=> (key_q == $past(key_wdata)));

  // R5: serial shift while unlocked, write absent.
  a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && key_sh && !key_wr) |=>
      (key_q == {$past(key_q[KEY_W-2:0]), $past(key_sin)}));

  // R6: lock is sticky and freezes the key.
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  a_r6_key_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(key_q));

  a_r6_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set |=> locked);

  // R7: match flag tracks the secret.
  a_r7_ok_secret: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && key_wr && key_wdata == CORRECT_KEY) |=> key_ok);

  // R8: valid follows, result holds.
  a_r8_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(y)));

endmodule

bind keylock_alu keylock_alu_chk #(
  .DATA_W      (DATA_W),
  .KEY_W       (KEY_W),
  .CORRECT_KEY (CORRECT_KEY)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .in_vld    (in_vld),
  .op_a      (op_a),
  .op_b      (op_b),
  .op_sel    (op_sel),
  .key_wr    (key_wr),
  .key_wdata (key_wdata),
  .key_sh    (key_sh),
  .key_sin   (key_sin),
  .lock_set  (lock_set),
  .key_q     (key_q),
  .y         (y),
  .out_vld   (out_vld),
  .key_ok    (key_ok),
  .locked    (locked)
);

// File: tb/tb_keylock_alu.sv
module tb_keylock_alu;

  localparam int          CLK_PERIOD = 10;
  localparam int          DW         = 8;
  localparam int          KW         = 8;
  localparam int          HW         = KW / 2;
  localparam logic [KW-1:0] SECRET   = 8'hA5;
  localparam logic [KW-1:0] FOLD     = 8'h3C;

  logic          clk;
  logic          rst_n;
  logic          in_vld;
  logic [DW-1:0] op_a;
  logic [DW-1:0] op_b;
  logic [1:0]    op_sel;
  logic          key_wr;
  logic [KW-1:0] key_wdata;
  logic          key_sh;
  logic          key_sin;
  logic          lock_set;
  logic [DW-1:0] y;
  logic          out_vld;
  logic          key_ok;
  logic          locked;

  keylock_alu #(
    .DATA_W      (DW),
    .KEY_W       (KW),
    .CORRECT_KEY (SECRET),
    .FOLD_MASK   (FOLD)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .key_wr    (key_wr),
    .key_wdata (key_wdata),
    .key_sh    (key_sh),
    .key_sin   (key_sin),
    .lock_set  (lock_set),
    .y         (y),
    .out_vld   (out_vld),
    .key_ok    (key_ok),
    .locked    (locked)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk;
  int n_fail;

  // Reference state.
  logic [KW-1:0] m_key;
  logic          m_lock;
  logic [DW-1:0] m_y;
  logic          m_vld;

  function automatic logic [DW-1:0] ref_fn(input logic [DW-1:0] a,
                                           input logic [DW-1:0] b,
                                           input logic [1:0] s,
                                           input logic [KW-1:0] k);
    logic [KW-1:0] wrong;
    logic [DW-1:0] ae;
    logic [DW-1:0] be;
    wrong = k ^ SECRET;
    ae = a;
    be = b;
    for (int i = 0; i < HW; i++) begin
      ae[i] = a[i] ^ wrong[i];
      be[i] = b[i] ^ wrong[i+HW];
    end
    case (s)
      2'd0:    ref_fn = ae + be;
      2'd1:    ref_fn = ae - be;
      2'd2:    ref_fn = ae & be;
      default: ref_fn = ae ^ be;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "y", 32'(y), 32'(m_y));
    chk(tag, "out_vld", 32'(out_vld), 32'(m_vld));
    chk(tag, "key_ok", 32'(key_ok), 32'(m_key == SECRET));
    chk(tag, "locked", 32'(locked), 32'(m_lock));
  endtask

  task automatic idle_inputs();
    in_vld = 0; op_a = '0; op_b = '0; op_sel = '0;
    key_wr = 0; key_wdata = '0; key_sh = 0; key_sin = 0; lock_set = 0;
  endtask

  // Inputs are already applied (at a negedge); advance one edge, update
  // the reference, then compare at the following negedge.
  task automatic step(input string tag);
    @(posedge clk);
    if (in_vld) m_y = ref_fn(op_a, op_b, op_sel, m_key);
    m_vld = in_vld;
    if (!m_lock) begin
      if (key_wr)      m_key = key_wdata;
      else if (key_sh) m_key = {m_key[KW-2:0], key_sin};
    end
    if (lock_set) m_lock = 1'b1;
    @(negedge clk);
    idle_inputs();
    compare(tag);
  endtask

  task automatic do_op(input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [1:0] s, input string tag);
    in_vld = 1; op_a = a; op_b = b; op_sel = s;
    step(tag);
  endtask

  task automatic wr_key(input logic [KW-1:0] k, input string tag);
    key_wr = 1; key_wdata = k;
    step(tag);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    m_key = '0; m_lock = 0; m_y = '0; m_vld = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    do_reset();
    // R1: reset state
    compare("R1");

    // R3: fresh (zero) key corrupts results
    do_op(8'h12, 8'h34, 2'd0, "R3");
    do_op(8'hF0, 8'h0F, 2'd3, "R3");
    do_op(8'h55, 8'hAA, 2'd2, "R3");

    // R4 / R7: load secret in parallel
    wr_key(8'h5A, "R4");
    wr_key(SECRET, "R7");

    // R2: all functions with the correct key, incl. wrap cases
    do_op(8'hFF, 8'h01, 2'd0, "R2");
    do_op(8'h00, 8'h01, 2'd1, "R2");
    do_op(8'hC3, 8'h5E, 2'd2, "R2");
    do_op(8'h9D, 8'h62, 2'd3, "R2");
    do_op(8'h80, 8'h80, 2'd0, "R2");
    do_op(8'h37, 8'hC9, 2'd1, "R2");

    // R3: one wrong bit at a time, each corrupting only its own net
    for (int i = 0; i < KW; i++) begin
      wr_key(SECRET ^ KW'(1 << i), "R3");
      do_op(8'h00, 8'h00, 2'd3, "R3");
      do_op(8'h6B, 8'h2D, 2'd0, "R3");
    end

    // R8: hold while not valid
    wr_key(SECRET, "R4");
    do_op(8'h11, 8'h22, 2'd0, "R8");
    op_a = 8'hEE; op_b = 8'hDD;
    step("R8");
    step("R8");

    // R5: serial load of the secret, MSB first
    wr_key('0, "R4");
    for (int i = KW - 1; i >= 0; i--) begin
      key_sh = 1; key_sin = SECRET[i];
      step("R5");
    end
    do_op(8'hA0, 8'h0B, 2'd1, "R5");
    // R5: write wins over shift
    key_wr = 1; key_wdata = 8'h3C; key_sh = 1; key_sin = 1;
    step("R5");
    key_sh = 1; key_sin = 0;
    step("R5");

    // R6: write in the lock cycle is accepted, later changes ignored
    key_wr = 1; key_wdata = SECRET; lock_set = 1;
    step("R6");
    wr_key(8'h00, "R6");
    key_sh = 1; key_sin = 1;
    step("R6");
    key_wr = 1; key_wdata = 8'hFF; key_sh = 1;
    step("R6");
    do_op(8'h7F, 8'h01, 2'd0, "R6");
    step("R6");

    // R1: reset clears lock and key again
    do_reset();
    compare("R1");
    wr_key(SECRET, "R4");
    do_op(8'h44, 8'h0C, 2'd1, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule